// File: doc/BRIEF.md
# Link Power-Status Interface Reset Sequencer

This block sits on the link-layer side of a link-to-physical-layer connection and controls how that connection is shut down and brought back. While the link power-status line `lps` is high, the block passes the request bit, the control bus and the data bus through to the pins and enables all three drivers. When the link asks for a shutdown in differentiated mode (`iso_mode` low), the block drops `lps` at once. It lets any transfer that is still in progress finish, but never beyond a deadline set in clock cycles. It then drives every line to 0 for one cycle and releases all three drivers.

After the release, the block waits out the time the physical layer needs to detect that `lps` has gone low. That wait is the reset phase. The block then holds a minimum restore interval before it may raise `lps` again. A restart request that arrives at any point during the shutdown is remembered and served as soon as the restore interval ends. The `phase` output reports where the sequence stands: 0 normal, 1 draining, 2 reset detect, 3 restore wait, 4 ready.

Top module: `lps_reset_seq`

## Requirements
- R1: After reset the block is in the ready phase (`phase`=4) with `lps` low, all three enables low and all data outputs 0.
- R2: In the ready phase a `restart_req` seen at a clock edge moves the block to normal (`phase`=0). In normal, `lps` is high, all enables are high, and `lreq_o`/`ctl_o`/`d_o` follow `lreq_in`/`ctl_in`/`d_in` in the same cycle.
- R3: In normal, a `shutdown_req` with `iso_mode` low moves the block to draining (`phase`=1) at the next edge, with `lps` low. While `tx_busy` stays high, the outputs keep following the inputs with all enables high.
- R4: A `shutdown_req` while `iso_mode` is high is ignored: the block stays in normal with `lps` high.
- R5: When `tx_busy` is low during draining, the next cycle drives all outputs to 0 with enables still high, still in `phase`=1. The cycle after that releases all enables and enters reset detect (`phase`=2).
- R6: From the edge that drops `lps`, enables stay high for at most DRAIN_CYC cycles, and for exactly DRAIN_CYC cycles when `tx_busy` never falls.
- R7: In the cycle before any enable falls, the output it gates is 0.
- R8: Reset detect lasts exactly DETECT_CYC cycles, with `lps` low and all enables low, and is followed by restore wait (`phase`=3).
- R9: Restore wait lasts exactly RESTORE_CYC cycles, with `lps` low and all enables low.
- R10: A `restart_req` seen during phases 1 to 3 is held, and the block goes from restore wait straight to normal. Without one, it goes to ready and stays there.
- R11: `shutdown_req` has no effect outside normal, and `restart_req` has no effect in normal.
- R12: `phase` changes only along 4→0, 0→1, 1→2, 2→3, 3→4 and 3→0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_mode | input | 1 | High selects the mode in which shutdown is not used |
| shutdown_req | input | 1 | Request to power the interface down |
| restart_req | input | 1 | Request to raise `lps` again |
| tx_busy | input | 1 | A request or bus transfer is still in progress |
| lreq_in | input | 1 | Request bit from the link core |
| ctl_in | input | CTL_W | Control bus value from the link core |
| d_in | input | DATA_W | Data bus value from the link core |
| lps | output | 1 | Link power status |
| lreq_o | output | 1 | Request line value |
| lreq_oe | output | 1 | Request line driver enable |
| ctl_o | output | CTL_W | Control bus value |
| ctl_oe | output | 1 | Control bus driver enable |
| d_o | output | DATA_W | Data bus value |
| d_oe | output | 1 | Data bus driver enable |
| phase | output | 3 | Current phase code (0 to 4) |

## Verification
A stuck or misordered state shows up at once on `phase`, and in the same cycle as a wrong combination of `lps` and the enables. One example is drivers still enabled in reset detect. A counter that is off by one only shows as a phase that lasts one cycle too long or too short. Measuring the length of every draining, detect and restore run in cycles therefore catches it at the next phase change. A lost restart request appears RESTORE_CYC cycles after reset detect ends, when the block settles in ready instead of raising `lps`.

// File: rtl/lps_reset_seq.sv
module lps_reset_seq #(
  parameter int DATA_W      = 8,
  parameter int CTL_W       = 2,
  parameter int DRAIN_CYC   = 125000,
  parameter int DETECT_CYC  = 64,
  parameter int RESTORE_CYC = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_mode,
  input  logic              shutdown_req,
  input  logic              restart_req,
  input  logic              tx_busy,
  input  logic              lreq_in,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic [DATA_W-1:0] d_in,
  output logic              lps,
  output logic              lreq_o,
  output logic              lreq_oe,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe,
  output logic [2:0]        phase
);
  localparam int MAXC = (DRAIN_CYC > DETECT_CYC) ?
                        ((DRAIN_CYC > RESTORE_CYC) ? DRAIN_CYC : RESTORE_CYC) :
                        ((DETECT_CYC > RESTORE_CYC) ? DETECT_CYC : RESTORE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DRAIN_LAST   = CW'(DRAIN_CYC - 2);
  localparam logic [CW-1:0] DETECT_LAST  = CW'(DETECT_CYC - 1);
  localparam logic [CW-1:0] RESTORE_LAST = CW'(RESTORE_CYC - 1);

  typedef enum logic [2:0] {
    S_NORMAL  = 3'd0,
    S_DRAIN   = 3'd1,
    S_DETECT  = 3'd2,
    S_RESTORE = 3'd3,
    S_READY   = 3'd4,
    S_ZERO    = 3'd5
  } state_t;

  state_t         state, state_nxt;
  logic [CW-1:0]  cnt;
  logic           pending;

  always_comb begin
    state_nxt = state;
    unique case (state)
      S_NORMAL:  if (shutdown_req && !iso_mode) state_nxt = S_DRAIN;
      S_DRAIN:   if (!tx_busy || cnt == DRAIN_LAST) state_nxt = S_ZERO;
      S_ZERO:    state_nxt = S_DETECT;
      S_DETECT:  if (cnt == DETECT_LAST) state_nxt = S_RESTORE;
      S_RESTORE: if (cnt == RESTORE_LAST)
                   state_nxt = (pending || restart_req) ? S_NORMAL : S_READY;
      S_READY:   if (restart_req) state_nxt = S_NORMAL;
      default:   state_nxt = S_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_READY;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state_nxt != state || state == S_NORMAL || state == S_READY)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
      if (state_nxt == S_NORMAL)
        pending <= 1'b0;
      else if (restart_req && state != S_NORMAL && state != S_READY)
        pending <= 1'b1;
    end
  end

  wire pass  = (state == S_NORMAL) || (state == S_DRAIN);
  wire drive = pass || (state == S_ZERO);

  assign lps     = (state == S_NORMAL);
  assign lreq_o  = pass ? lreq_in : 1'b0;
  assign ctl_o   = pass ? ctl_in  : '0;
  assign d_o     = pass ? d_in    : '0;
  assign lreq_oe = drive;
  assign ctl_oe  = drive;
  assign d_oe    = drive;
  assign phase   = (state == S_ZERO) ? 3'd1 : 3'(state);
endmodule

// File: rtl/lps_reset_seq_chk.sv
module lps_reset_seq_chk #(
  parameter int DATA_W      = 8,
  parameter int CTL_W       = 2,
  parameter int DRAIN_CYC   = 125000,
  parameter int DETECT_CYC  = 64,
  parameter int RESTORE_CYC = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iso_mode,
  input logic              shutdown_req,
  input logic              lps,
  input logic              lreq_o,
  input logic              lreq_oe,
  input logic [CTL_W-1:0]  ctl_o,
  input logic              ctl_oe,
  input logic [DATA_W-1:0] d_o,
  input logic              d_oe,
  input logic [2:0]        phase
);
  int drain_run, detect_run, restore_run;
  wire any_oe = lreq_oe || ctl_oe || d_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_run   <= 0;
      detect_run  <= 0;
      restore_run <= 0;
    end else begin
      drain_run   <= (!lps && any_oe) ? drain_run + 1 : 0;
      detect_run  <= (phase == 3'd2) ? detect_run + 1 : 0;
      restore_run <= (phase == 3'd3) ? restore_run + 1 : 0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (phase == 3'd4 && !lps && !any_oe)); // R1
  AST_LPS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) lps |-> (lreq_oe && ctl_oe && d_oe && phase == 3'd0)); // R2
  AST_ISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (phase == 3'd0 && iso_mode && shutdown_req) |=> (phase == 3'd0 && lps)); // R4
  AST_DRAIN_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n) (!lps && any_oe) |-> (drain_run < DRAIN_CYC)); // R6
  AST_LREQ_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(lreq_oe) |-> ($past(lreq_o) == 1'b0)); // R7
  AST_CTL_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(ctl_oe) |-> ($past(ctl_o) == '0)); // R7
  AST_D_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(d_oe) |-> ($past(d_o) == '0)); // R7
  AST_DETECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (phase == 3'd2 || phase == 3'd3) |-> (!lps && !any_oe)); // R8
  AST_DETECT_LEN: assert property (@(posedge clk) disable iff (!rst_n) ($past(phase) == 3'd2 && phase != 3'd2) |-> (detect_run == DETECT_CYC)); // R8
  AST_RESTORE_LEN: assert property (@(posedge clk) disable iff (!rst_n) ($past(phase) == 3'd3 && phase != 3'd3) |-> (restore_run == RESTORE_CYC)); // R9
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (phase != $past(phase)) |->
    ({$past(phase), phase} inside {6'o40, 6'o01, 6'o12, 6'o23, 6'o34, 6'o30})); // R12
endmodule

bind lps_reset_seq lps_reset_seq_chk #(
  .DATA_W(DATA_W), .CTL_W(CTL_W), .DRAIN_CYC(DRAIN_CYC),
  .DETECT_CYC(DETECT_CYC), .RESTORE_CYC(RESTORE_CYC)
) u_chk (.*);

// File: tb/lps_reset_seq_test.sv
`timescale 1ns/1ps
module lps_reset_seq_test;
  localparam int DW = 8, CW = 2;
  localparam int DRAIN = 6, DETECT = 4, RESTORE = 5;
  localparam int NV = 11;

  logic clk = 0, rst_n = 0;
  logic iso_mode = 0, shutdown_req = 0, restart_req = 0, tx_busy = 0, lreq_in = 0;
  logic [CW-1:0] ctl_in = '0;
  logic [DW-1:0] d_in = '0;
  logic lps, lreq_o, lreq_oe, ctl_oe, d_oe;
  logic [CW-1:0] ctl_o;
  logic [DW-1:0] d_o;
  logic [2:0] phase;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lps_reset_seq #(.DATA_W(DW), .CTL_W(CW), .DRAIN_CYC(DRAIN),
                  .DETECT_CYC(DETECT), .RESTORE_CYC(RESTORE)) uut (.*);

  // inputs {shut, restart, busy, iso, lreq, ctl, d} ; expected {phase, lps, oe[lreq,ctl,d], lreq, ctl, d}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,8'h00, 3'd4,1'b0,3'b000,1'b0,2'b00,8'h00}, // R1
    {1'b0,1'b1,1'b0,1'b0,1'b1,2'b10,8'hA5, 3'd4,1'b0,3'b000,1'b0,2'b00,8'h00}, // R1
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,8'h3C, 3'd0,1'b1,3'b111,1'b0,2'b01,8'h3C}, // R2
    {1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,8'h11, 3'd0,1'b1,3'b111,1'b1,2'b11,8'h11}, // R2
    {1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,8'h22, 3'd0,1'b1,3'b111,1'b0,2'b10,8'h22}, // R4
    {1'b1,1'b0,1'b1,1'b0,1'b1,2'b01,8'h33, 3'd0,1'b1,3'b111,1'b1,2'b01,8'h33}, // R2
    {1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,8'h44, 3'd1,1'b0,3'b111,1'b0,2'b11,8'h44}, // R3
    {1'b0,1'b0,1'b1,1'b0,1'b1,2'b10,8'h55, 3'd1,1'b0,3'b111,1'b1,2'b10,8'h55}, // R3
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,8'h66, 3'd1,1'b0,3'b111,1'b1,2'b01,8'h66}, // R3
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,8'h77, 3'd1,1'b0,3'b111,1'b0,2'b00,8'h00}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,8'h88, 3'd2,1'b0,3'b000,1'b0,2'b00,8'h00}  // R5
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R1";
      2, 3, 5: return "R2";
      4: return "R4";
      6, 7, 8: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [17:0] snap();
    return {phase, lps, lreq_oe, ctl_oe, d_oe, lreq_o, ctl_o, d_o};
  endfunction

  initial begin
    int n;
    logic [17:0] prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      if (i > 0) step();
      {shutdown_req, restart_req, tx_busy, iso_mode, lreq_in, ctl_in, d_in} = VEC[i][33:18];
      #1;
      check(vtag(i), 32'(snap()), 32'(VEC[i][17:0]));
    end

    n = 1;
    for (int k = 0; k < 50; k++) begin
      step(); #1;
      if (phase != 3'd2) break;
      n++;
    end
    check("R8", 32'(n), 32'(DETECT));
    check("R8", 32'(phase), 32'd3);

    n = 1;
    for (int k = 0; k < 50; k++) begin
      if (lps) check("R9", 32'(lps), 32'd0);
      step(); #1;
      if (phase != 3'd3) break;
      n++;
    end
    check("R9", 32'(n), 32'(RESTORE));
    check("R10", 32'(phase), 32'd4);

    shutdown_req = 1;
    step(); step(); #1;
    shutdown_req = 0;
    check("R11", 32'({phase, lps}), 32'({3'd4, 1'b0}));

    restart_req = 1;
    step();
    restart_req = 0; #1;
    check("R2", 32'({phase, lps}), 32'({3'd0, 1'b1}));
    restart_req = 1;
    step();
    restart_req = 0;
    step(); #1;
    check("R11", 32'({phase, lps}), 32'({3'd0, 1'b1}));

    tx_busy = 1; d_in = 8'hFF; ctl_in = 2'b11; lreq_in = 1;
    shutdown_req = 1;
    step();
    shutdown_req = 0; #1;
    n = 0;
    prev = snap();
    for (int k = 0; k < 50; k++) begin
      if (!(lps == 0 && (lreq_oe || ctl_oe || d_oe))) break;
      n++;
      prev = snap();
      step(); #1;
    end
    check("R6", 32'(n), 32'(DRAIN));
    check("R7", 32'(prev[10:0]), 32'd0);
    check("R5", 32'({phase, lreq_oe, ctl_oe, d_oe}), 32'({3'd2, 3'b000}));
    tx_busy = 0;

    restart_req = 1;
    step();
    restart_req = 0;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      step(); #1;
      if (phase == 3'd3) n++;
      else if (phase != 3'd2) break;
    end
    check("R10", 32'(n), 32'(RESTORE));
    check("R10", 32'({phase, lps}), 32'({3'd0, 1'b1}));

    rst_n = 0;
    step(); #1;
    check("R1", 32'(snap()), 32'({3'd4, 15'd0}));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule